// File: doc/BRIEF.md
# Per-Phase Apparent Energy Accumulator

This block integrates apparent power into three independent energy accumulators, one per phase of a three-phase supply. Each phase receives an rms voltage sample and an rms current sample. On every cycle where the shared sample strobe is high, each phase multiplies the two rms samples, applies its own gain, divides the result by a common divider and adds it into a wide internal integrator. Only the upper bits of each integrator can be read.

A 2-bit source field sets how the product is formed. In one code the current path skips its gain. In two codes the current gain is applied. The fourth code is reserved and adds nothing. An integrator that would pass full scale stops at its maximum value and sets a sticky overflow flag for that phase. A synchronous clear input returns all three phases to zero. The rms computation and any smoothing filter sit upstream and are outside this block. The block treats its inputs as already filtered.

Top module: `va_energy_acc`

## Requirements
- R1: While rst_ni is low, and after it is released before any sample, every energy output and every overflow flag reads 0.
- R2: A phase changes state only on a clock edge where valid_i or clr_i is high. On a sample edge its integrator increases by q = floor(Pg / D), where Pg is the gained power (R6) and D is the divider (R7). Between strobes the outputs hold, whatever the other inputs do.
- R3: With src_i = 2'b00, the current gain is bypassed, so the power is P = V * I with unsigned V and I.
- R4: With src_i = 2'b01 or 2'b10, the current first becomes Ig = floor(I * (4096 + gi) / 4096), and P = V * Ig. Here gi is that phase's signed two's-complement 12-bit current gain.
- R5: With src_i = 2'b11 (reserved), every phase adds zero on a sample edge.
- R6: The gained power is Pg = floor(P * (4096 + ga) / 4096), where ga is that phase's signed two's-complement 12-bit power gain.
- R7: The unsigned 8-bit divider D divides Pg. The value 0 acts as a divider of 1.
- R8: Each energy output is bits [ACC_W-1 : ACC_W-OUT_W] of that phase's integrator.
- R9: When an addition would exceed 2^ACC_W - 1, the integrator stays at 2^ACC_W - 1 and that phase's overflow flag is set. The flag stays set until cleared.
- R10: clr_i high on a clock edge zeroes all three integrators and overflow flags. It takes priority over a sample on the same edge.
- R11: Phases are independent. Phase k uses slice [k*W +: W] of each packed input and output, where phase A is k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all integrators and flags |
| valid_i | input | 1 | Sample strobe shared by all phases |
| src_i | input | 2 | Power source select |
| vrms_i | input | 3*RMS_W | Per-phase rms voltage, unsigned |
| irms_i | input | 3*RMS_W | Per-phase rms current, unsigned |
| igain_i | input | 36 | Per-phase signed current gain |
| pgain_i | input | 36 | Per-phase signed power gain |
| div_i | input | 8 | Common divider, 0 acts as 1 |
| energy_o | output | 3*OUT_W | Per-phase upper integrator bits |
| ovf_o | output | 3 | Per-phase sticky overflow flags |

## Verification
The assertions check the cycle-level rules on every cycle. Outputs hold between strobes. The reserved code leaves energy untouched. Energy never decreases without a clear. A clear empties everything on the next edge. A set overflow flag stays set and pins its energy at full scale.

Only the bench's sweeps can show that the arithmetic is right. They cover every source code, signed gains at both extremes, dividers of 0, 1, 3 and 255, and distinct values per phase. The bench also drives a long run into saturation.

// File: rtl/vea_pkg.sv
package vea_pkg;
  localparam int unsigned GAIN_W = 12;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned N_PH   = 3;

  typedef enum logic [1:0] {
    SRC_RAW  = 2'b00,
    SRC_IG_A = 2'b01,
    SRC_IG_B = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;
endpackage

// File: rtl/vea_gain.sv
// y = floor(x * (2^GW + g) / 2^GW), g signed
module vea_gain #(
  parameter int unsigned XW = 12,
  parameter int unsigned GW = 12
) (
  input  logic [XW-1:0] x_i,
  input  logic [GW-1:0] g_i,
  output logic [XW:0]   y_o
);
  localparam int unsigned KW = GW + 1;
  localparam int unsigned PW = XW + KW;
  localparam logic [KW-1:0] UNITY = {1'b1, {GW{1'b0}}};

  logic [KW-1:0] k;
  logic [PW-1:0] prod;

  assign k    = UNITY + {g_i[GW-1], g_i};
  assign prod = {{KW{1'b0}}, x_i} * {{XW{1'b0}}, k};
  assign y_o  = (XW+1)'(prod >> GW);
endmodule

// File: rtl/vea_sat_acc.sv
module vea_sat_acc #(
  parameter int unsigned IN_W  = 26,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IN_W-1:0]  add_i,
  output logic [OUT_W-1:0] energy_o,
  output logic             ovf_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(add_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      ovf_o <= 1'b0;
    end else if (en_i) begin
      if (sum[ACC_W]) begin
        acc_q <= '1;
        ovf_o <= 1'b1;
      end else begin
        acc_q <= sum[ACC_W-1:0];
      end
    end
  end

  assign energy_o = acc_q[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/vea_phase.sv
module vea_phase
  import vea_pkg::*;
#(
  parameter int unsigned RMS_W = 12,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  src_e              src_i,
  input  logic [RMS_W-1:0]  v_i,
  input  logic [RMS_W-1:0]  i_i,
  input  logic [GAIN_W-1:0] igain_i,
  input  logic [GAIN_W-1:0] pgain_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [OUT_W-1:0]  energy_o,
  output logic              ovf_o
);
  localparam int unsigned IW = RMS_W + 1;
  localparam int unsigned PW = RMS_W + IW;
  localparam int unsigned AW = PW + 1;

  logic [IW-1:0]    i_gained, i_eff;
  logic [PW-1:0]    pwr;
  logic [AW-1:0]    pwr_g, quo, add;
  logic [DIV_W-1:0] div_eff;

  vea_gain #(.XW(RMS_W), .GW(GAIN_W)) i_igain (
    .x_i(i_i), .g_i(igain_i), .y_o(i_gained)
  );

  assign i_eff = (src_i == SRC_RAW) ? {1'b0, i_i} : i_gained;
  assign pwr   = PW'(v_i) * PW'(i_eff);

  vea_gain #(.XW(PW), .GW(GAIN_W)) i_pgain (
    .x_i(pwr), .g_i(pgain_i), .y_o(pwr_g)
  );

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign quo     = pwr_g / AW'(div_eff);
  assign add     = (src_i == SRC_RSVD) ? '0 : quo;

  vea_sat_acc #(.IN_W(AW), .ACC_W(ACC_W), .OUT_W(OUT_W)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(valid_i),
    .add_i(add), .energy_o(energy_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/va_energy_acc.sv
module va_energy_acc
  import vea_pkg::*;
#(
  parameter int unsigned RMS_W = 12,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    valid_i,
  input  logic [1:0]              src_i,
  input  logic [3*RMS_W-1:0]      vrms_i,
  input  logic [3*RMS_W-1:0]      irms_i,
  input  logic [3*GAIN_W-1:0]     igain_i,
  input  logic [3*GAIN_W-1:0]     pgain_i,
  input  logic [DIV_W-1:0]        div_i,
  output logic [3*OUT_W-1:0]      energy_o,
  output logic [2:0]              ovf_o
);
  src_e src;
  assign src = src_e'(src_i);

  for (genvar k = 0; k < N_PH; k++) begin : g_ph
    vea_phase #(.RMS_W(RMS_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) i_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .valid_i (valid_i),
      .src_i   (src),
      .v_i     (vrms_i[k*RMS_W +: RMS_W]),
      .i_i     (irms_i[k*RMS_W +: RMS_W]),
      .igain_i (igain_i[k*GAIN_W +: GAIN_W]),
      .pgain_i (pgain_i[k*GAIN_W +: GAIN_W]),
      .div_i   (div_i),
      .energy_o(energy_o[k*OUT_W +: OUT_W]),
      .ovf_o   (ovf_o[k])
    );
  end
endmodule

// File: rtl/vea_checker.sv
module vea_checker #(
  parameter int unsigned OUT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               valid_i,
  input logic [1:0]         src_i,
  input logic [3*OUT_W-1:0] energy_o,
  input logic [2:0]         ovf_o
);
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> ($stable(energy_o) && $stable(ovf_o)));

  a_r5_rsvd_no_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == 2'b11 && !clr_i) |=> $stable(energy_o));

  a_r10_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (energy_o == '0 && ovf_o == '0));

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  for (genvar k = 0; k < 3; k++) begin : g_ph
    a_r9_ovf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o[k] |-> (energy_o[k*OUT_W +: OUT_W] == {OUT_W{1'b1}}));

    a_r2_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (energy_o[k*OUT_W +: OUT_W] >= $past(energy_o[k*OUT_W +: OUT_W])));
  end
endmodule

bind va_energy_acc vea_checker #(.OUT_W(OUT_W)) i_vea_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .valid_i (valid_i),
  .src_i   (src_i),
  .energy_o(energy_o),
  .ovf_o   (ovf_o)
);

// File: tb/test_va_energy_acc.sv
module test_va_energy_acc;
  localparam int RMS_W = 12;
  localparam int ACC_W = 32;
  localparam int OUT_W = 16;
  localparam longint unsigned ACC_MAX = (64'd1 << ACC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, valid = 1'b0;
  logic [1:0] src = 2'b00;
  logic [3*RMS_W-1:0] vrms = '0, irms = '0;
  logic [35:0] igain = '0, pgain = '0;
  logic [7:0] div = '0;
  logic [3*OUT_W-1:0] energy;
  logic [2:0] ovf;

  int n_run = 0, n_fail = 0;
  int vv[3], ii[3], igs[3], pgs[3];
  int cur_m = 0, cur_d = 0;
  longint unsigned m_acc[3];
  bit m_ovf[3];

  always #10 clk = ~clk;

  va_energy_acc #(.RMS_W(RMS_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) i_va_energy_acc (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(valid), .src_i(src),
    .vrms_i(vrms), .irms_i(irms), .igain_i(igain), .pgain_i(pgain),
    .div_i(div), .energy_o(energy), .ovf_o(ovf)
  );

  function automatic longint unsigned model_q(int m, int v, int i, int ig, int pg, int d);
    longint unsigned ie, p, pa, dd;
    if (m == 3) return 0;
    ie = (m == 0) ? longint'(i) : (longint'(i) * longint'(4096 + ig)) >> 12;
    p  = longint'(v) * ie;
    pa = (p * longint'(4096 + pg)) >> 12;
    dd = (d == 0) ? 1 : longint'(d);
    return pa / dd;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 3; k++) begin m_acc[k] = 0; m_ovf[k] = 0; end
  endtask

  task automatic model_sample();
    for (int k = 0; k < 3; k++) begin
      longint unsigned s;
      s = m_acc[k] + model_q(cur_m, vv[k], ii[k], igs[k], pgs[k], cur_d);
      if (s > ACC_MAX) begin m_acc[k] = ACC_MAX; m_ovf[k] = 1; end
      else m_acc[k] = s;
    end
  endtask

  task automatic drive();
    for (int k = 0; k < 3; k++) begin
      vrms[k*RMS_W +: RMS_W] = vv[k][RMS_W-1:0];
      irms[k*RMS_W +: RMS_W] = ii[k][RMS_W-1:0];
      igain[k*12 +: 12]      = igs[k][11:0];
      pgain[k*12 +: 12]      = pgs[k][11:0];
    end
    src = cur_m[1:0];
    div = cur_d[7:0];
  endtask

  task automatic check_state(input string req);
    for (int k = 0; k < 3; k++) begin
      longint unsigned e;
      e = m_acc[k] >> (ACC_W - OUT_W);
      n_run++;
      if (energy[k*OUT_W +: OUT_W] !== e[OUT_W-1:0]) begin
        n_fail++;
        $display("FAIL %s phase %0d energy: actual=%0h expected=%0h",
                 req, k, energy[k*OUT_W +: OUT_W], e[OUT_W-1:0]);
      end
      n_run++;
      if (ovf[k] !== m_ovf[k]) begin
        n_fail++;
        $display("FAIL %s phase %0d ovf: actual=%0b expected=%0b", req, k, ovf[k], m_ovf[k]);
      end
    end
  endtask

  task automatic step(input string req);
    @(negedge clk);
    drive();
    valid = 1'b1;
    @(posedge clk);
    model_sample();
    @(negedge clk);
    valid = 1'b0;
    check_state(req);
  endtask

  task automatic do_clear(input bit with_valid);
    @(negedge clk);
    drive();
    clr = 1'b1;
    valid = with_valid;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    clr = 1'b0;
    valid = 1'b0;
    check_state("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ig_set[4] = '{0, 2047, -2048, -1};
    int pg_set[4] = '{0, -2048, 2047, 1000};
    int d_set[4]  = '{0, 1, 3, 255};
    model_clear();
    for (int k = 0; k < 3; k++) begin vv[k] = 0; ii[k] = 0; igs[k] = 0; pgs[k] = 0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // Sweep: source codes R3/R4/R5, gains R6, dividers R7, readout R8, per-phase slices R11
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 4; g++) begin
        for (int d = 0; d < 4; d++) begin
          string req;
          req = (m == 3) ? "R5 R2" : (m == 0) ? "R3 R2 R6 R7 R8" : "R4 R2 R6 R7 R8";
          cur_m = m;
          cur_d = d_set[d];
          for (int k = 0; k < 3; k++) begin
            igs[k] = ig_set[(g + k) % 4];
            pgs[k] = pg_set[(g + k) % 4];
          end
          do_clear(1'b0);
          for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < 3; k++) begin
              vv[k] = 4095 - s * 613 - k * 211;
              ii[k] = 4095 - ((s * 389 + k * 997) % 4096);
            end
            step(req);
          end
          // R2: inputs move without strobe, outputs hold
          @(negedge clk);
          cur_m = (m + 1) % 4;
          vv[0] = 17; ii[1] = 99;
          drive();
          repeat (3) @(negedge clk);
          check_state("R2 hold");
        end
      end
    end

    // R11: only phase B carries power
    cur_m = 1; cur_d = 0;
    for (int k = 0; k < 3; k++) begin igs[k] = 0; pgs[k] = 0; end
    do_clear(1'b0);
    vv[0] = 0; ii[0] = 4000; vv[1] = 4000; ii[1] = 4000; vv[2] = 4000; ii[2] = 0;
    repeat (4) step("R11");

    // R10: clear wins over a simultaneous sample
    do_clear(1'b1);

    // R9: drive to saturation
    for (int k = 0; k < 3; k++) begin vv[k] = 4095; ii[k] = 4095; igs[k] = 2047; pgs[k] = 2047; end
    cur_m = 2; cur_d = 0;
    repeat (130) step("R9");
    n_run++;
    if (ovf !== 3'b111 || energy !== {3*OUT_W{1'b1}}) begin
      n_fail++;
      $display("FAIL R9 saturation: actual ovf=%b energy=%0h expected ovf=111 energy=all ones",
               ovf, energy);
    end
    repeat (3) step("R9");
    do_clear(1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule